// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block regulates the current in one H-bridge by chopping. While the bridge conducts, a synchronous comparator input reports that the sensed current has crossed its reference. When that report is accepted, the block requests the bridge off for a programmed number of clock cycles. It then requests conduction again. Because the interval is timed from the trip, the chopping period follows the load rather than a fixed frequency.

The comparator is not trusted right after each turn-on. Diode recovery spikes would trip it falsely, and a minimum conduction time must be kept in any case. Both rules are folded into one acceptance gate measured in clock cycles from the turn-on edge. Blanking and minimum on time are given in nanoseconds and converted with the clock-frequency parameter. The off-phase output marks every off cycle, so that downstream gate logic can pick the recirculation style. The gate dead time is inserted downstream and adds to the programmed interval.

Top module: `chop_ctrl`

## Requirements
- R1: After reset, and in the cycle after `en_i` is sampled low, `bridge_on_o` and `off_phase_o` are both 0 and any pending off interval is discarded.
- R2: When `en_i` is sampled high while the block is disabled, `bridge_on_o` is 1 from the following cycle.
- R3: During the blanking window of BLANK_CYC = ceil(CLK_HZ*BLANK_NS/1e9) cycles after each turn-on, `trip_i` has no effect. A trip that is gone before the window closes never turns the bridge off.
- R4: The comparator is accepted only from on-cycle index GATE = max(BLANK_CYC, MIN_ON_CYC, 1) onward, where MIN_ON_CYC = ceil(CLK_HZ*MIN_ON_NS/1e9) and index 0 is the first cycle with `bridge_on_o` high. Every on phase that ends in an off phase therefore lasts at least GATE+1 cycles.
- R5: A trip sampled high at on-cycle index k >= GATE turns `bridge_on_o` to 0 and `off_phase_o` to 1 in the next cycle. The on phase then lasts k+1 cycles.
- R6: The off phase lasts exactly the value of `off_cycles_i` sampled with the accepted trip. Changes to `off_cycles_i` during the off phase do not alter it.
- R7: When the off interval ends, `bridge_on_o` returns to 1 and the acceptance gate restarts from index 0.
- R8: A trip that is asserted during the gate window and still asserted when the window closes is acted on at index GATE.
- R9: `bridge_on_o` and `off_phase_o` are never 1 together, and an off phase is entered only from an on phase.
- R10: An `off_cycles_i` value of 0 is treated as 1, giving a one-cycle off phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low forces the bridge off and clears timing |
| trip_i | input | 1 | Synchronous comparator: sensed current above reference |
| off_cycles_i | input | OFF_W | Off interval length in clock cycles |
| bridge_on_o | output | 1 | Bridge conduction request |
| off_phase_o | output | 1 | High for every cycle of an off interval |

## Verification
Some properties are checked on every cycle. The two outputs must be mutually exclusive. Disable must take effect one cycle later. An off phase may begin only after an on phase of at least GATE+1 cycles, and an off phase must end in conduction unless enable was removed. Other behaviours only the bench scenarios can show. These are the exact on-phase length for trips at given indices, the discarding of trips that fall wholly inside the window, and a held trip firing exactly when the window closes. The bench also covers the off-interval length taken from the value latched at the trip, and the zero-value rule.

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BLANK_NS  = 1000,
  parameter int MIN_ON_NS = 1500,
  parameter int OFF_W     = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             trip_i,
  input  logic [OFF_W-1:0] off_cycles_i,
  output logic             bridge_on_o,
  output logic             off_phase_o
);

  localparam longint KHZ        = longint'(CLK_HZ) / 1000;
  localparam int     BLANK_CYC  = int'((KHZ * BLANK_NS + 999_999) / 1_000_000);
  localparam int     MIN_ON_CYC = int'((KHZ * MIN_ON_NS + 999_999) / 1_000_000);
  localparam int     GATE_RAW   = (BLANK_CYC > MIN_ON_CYC) ? BLANK_CYC : MIN_ON_CYC;
  localparam int     GATE       = (GATE_RAW < 1) ? 1 : GATE_RAW;
  localparam int     ONW        = $clog2(GATE + 1);
  localparam logic [ONW-1:0] GATE_V = ONW'(GATE);

  typedef enum logic [1:0] {S_IDLE, S_ON, S_OFF} st_t;

  st_t              st;
  logic [ONW-1:0]   on_idx;
  logic [OFF_W-1:0] off_left;
  logic             armed;

  assign armed       = (on_idx == GATE_V);
  assign bridge_on_o = (st == S_ON);
  assign off_phase_o = (st == S_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      on_idx   <= '0;
      off_left <= '0;
    end else if (!en_i) begin
      st       <= S_IDLE;
      on_idx   <= '0;
      off_left <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          st     <= S_ON;
          on_idx <= '0;
        end
        S_ON: begin
          if (armed && trip_i) begin
            st       <= S_OFF;
            off_left <= (off_cycles_i == '0) ? OFF_W'(1) : off_cycles_i;
          end else if (!armed) begin
            on_idx <= on_idx + 1'b1;
          end
        end
        S_OFF: begin
          if (off_left <= OFF_W'(1)) begin
            st     <= S_ON;
            on_idx <= '0;
          end else begin
            off_left <= off_left - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BLANK_NS  = 1000,
  parameter int MIN_ON_NS = 1500
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic bridge_on,
  input logic off_phase
);
  localparam longint KHZ      = longint'(CLK_HZ) / 1000;
  localparam int     B_CYC    = int'((KHZ * BLANK_NS + 999_999) / 1_000_000);
  localparam int     M_CYC    = int'((KHZ * MIN_ON_NS + 999_999) / 1_000_000);
  localparam int     G_RAW    = (B_CYC > M_CYC) ? B_CYC : M_CYC;
  localparam int     G        = (G_RAW < 1) ? 1 : G_RAW;

  int on_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_run <= 0;
    else if (bridge_on) on_run <= (on_run < G + 1) ? on_run + 1 : on_run;
    else on_run <= 0;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bridge_on && off_phase)); // R9
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bridge_on && !off_phase)); // R1
  AST_OFF_FROM_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_phase) |-> $past(bridge_on)); // R9
  AST_MIN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_phase) |-> (on_run >= G + 1)); // R4
  AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(off_phase) && $past(en)) |-> bridge_on); // R7
endmodule

bind chop_ctrl chop_ctrl_chk #(.CLK_HZ(CLK_HZ), .BLANK_NS(BLANK_NS), .MIN_ON_NS(MIN_ON_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_i), .bridge_on(bridge_on_o), .off_phase(off_phase_o));

// File: tb/chop_ctrl_bench.sv
`timescale 1ns/1ps
module chop_ctrl_bench;
  localparam int OFF_W = 20;
  // CLK_HZ 4 MHz: blanking 4 cycles, min on 6 cycles, so GATE = 6
  localparam int GATE = 6;

  logic clk = 0, rst_n = 0, en = 0, trip = 0;
  logic [OFF_W-1:0] offv = '0;
  logic bon, offp;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chop_ctrl #(.CLK_HZ(4_000_000), .BLANK_NS(1000), .MIN_ON_NS(1500), .OFF_W(OFF_W)) u_chop_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en), .trip_i(trip), .off_cycles_i(offv),
    .bridge_on_o(bon), .off_phase_o(offp));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // off value, trip start index, trip length, expected on cycles (0 = no trip accepted), expected off cycles
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{10,  8,  1,  9,  10},   // R5 R6
    '{3,   0,  20, 7,  3},    // R8 R4
    '{5,   0,  4,  0,  0},    // R3
    '{5,   4,  2,  0,  0},    // R4
    '{0,   6,  1,  7,  1},    // R10
    '{1,   10, 3,  11, 1},    // R5
    '{200, 20, 1,  21, 200}   // R6
  };

  task automatic restart();
    en = 0; trip = 0;
    @(negedge clk); @(negedge clk);
    en = 1;
    @(negedge clk);
    chk(bon == 1, "R2 turn-on", bon, 1);
  endtask

  task automatic measure_on(input int st, input int ln, output int k);
    k = 0;
    while (bon && k < 60) begin
      trip = (k >= st && k < st + ln);
      @(negedge clk);
      k++;
    end
    trip = 0;
  endtask

  task automatic measure_off(output int n);
    n = 0;
    while (offp && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int k, n;
    repeat (3) @(negedge clk);
    chk(bon == 0 && offp == 0, "R1 reset state", {bon, offp}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(bon == 0 && offp == 0, "R1 disabled after reset", {bon, offp}, 0);

    for (int i = 0; i < NV; i++) begin
      offv = OFF_W'(VEC[i][0]);
      restart();
      measure_on(VEC[i][1], VEC[i][2], k);
      if (VEC[i][3] == 0) begin
        chk(k == 60 && bon == 1, $sformatf("R3/R4 vec%0d trip ignored", i), k, 60);
      end else begin
        chk(k == VEC[i][3] && offp == 1, $sformatf("R5 vec%0d on length", i), k, VEC[i][3]);
        measure_off(n);
        chk(n == VEC[i][4], $sformatf("R6 vec%0d off length", i), n, VEC[i][4]);
        chk(bon == 1, $sformatf("R7 vec%0d resume", i), bon, 1);
      end
    end

    // R6: off value changed during off phase has no effect
    offv = OFF_W'(50);
    restart();
    measure_on(GATE, 1, k);
    chk(k == GATE + 1, "R6 latch on length", k, GATE + 1);
    offv = OFF_W'(2);
    measure_off(n);
    chk(n == 50, "R6 latched off length", n, 50);

    // R7 R8: trip held high continuously, blanking reapplied after resume
    offv = OFF_W'(4);
    restart();
    trip = 1;
    k = 0; while (bon && k < 60) begin @(negedge clk); k++; end
    chk(k == GATE + 1, "R8 held trip first on", k, GATE + 1);
    n = 0; while (offp && n < 60) begin @(negedge clk); n++; end
    chk(n == 4, "R6 held trip off", n, 4);
    k = 0; while (bon && k < 60) begin @(negedge clk); k++; end
    chk(k == GATE + 1, "R7 gate restarts after resume", k, GATE + 1);
    trip = 0;

    // R1: disable during off phase discards the interval
    offv = OFF_W'(100);
    restart();
    measure_on(GATE, 1, k);
    @(negedge clk); @(negedge clk);
    chk(offp == 1, "R1 pre-disable off phase", offp, 1);
    en = 0;
    @(negedge clk);
    chk(bon == 0 && offp == 0, "R1 disable clears", {bon, offp}, 0);
    en = 1;
    @(negedge clk);
    chk(bon == 1 && offp == 0, "R1 R2 fresh start after disable", {bon, offp}, 2);

    // R1: disable during on phase
    en = 0;
    @(negedge clk);
    chk(bon == 0, "R1 disable during on", bon, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule